// File: doc/BRIEF.md
# Parallel Flash Identifier Read Responder

This block stands in for the read side of a bank of parallel NOR flash devices. A write port takes command bytes. One command switches the bank into identifier mode and another switches it back to array-read mode. While identifier mode is active, each read returns either the manufacturer code or the device code. Which code comes back depends on the read address.

The address is normalised against the widest mode the device can run in, not the width it is configured for. A device run narrower than its maximum therefore sees its identifier slots at addresses spread further apart. The selected code is copied into every device lane of the bank word. A read wider than the bank is built from several bank-wide lookups at consecutive bank offsets.

A configuration with device width zero keeps an older decode. That decode returns one of two fixed 16-bit words. In array mode, reads return a fixed filler byte in every requested byte. Read data is registered and arrives one clock after the request, together with a valid strobe.

Top module: `flash_id_responder`

## Requirements
- R1: After reset the block is in array mode and `rd_valid` is low.
- R2: A write of command byte 0x90 selects identifier mode. A write of 0xFF selects array mode. Any other command byte leaves the mode unchanged.
- R3: In array mode a read returns the byte `ARRAY_BYTE` (default 0xA5) in every requested byte.
- R4: `rd_valid` is high in the cycle after a cycle with `rd_en` high, and low otherwise. A read uses the mode as it stood before any write in the same cycle.
- R5: In identifier mode, with `DEV_W` nonzero, the index is the byte offset shifted right by log2(`BANK_W`) + log2(`MAX_DEV_W`) − log2(`DEV_W`). Only the low 8 bits of the index are decoded. Index 0 gives `MFR_CODE`, index 1 gives `DEV_CODE`, and every other index (2 and 3 included) gives zero.
- R6: The selected 16-bit code, zero-extended, fills the low `DEV_W` bytes of every `DEV_W`-byte slice of the bank word, starting at slice 0.
- R7: A read of more than `BANK_W` bytes is assembled from bank-wide lookups. Chunk i uses offset `rd_addr` + i·`BANK_W` and lands in bytes i·`BANK_W` upward.
- R8: A read returns 2^`rd_size` bytes in the low bytes of `rd_data`. `rd_size` is clamped to log2(`DATA_BYTES`). All higher bytes are zero.
- R9: With `DEV_W` = 0, the index is the low 8 offset bits shifted right by 1 for `BANK_W` = 2, by 2 for `BANK_W` = 4, and by 0 otherwise. Index 0 gives `LEGACY_ID[31:16]`, index 1 gives `LEGACY_ID[15:0]`, and any other index gives zero. The result sits in bytes 0 and 1, and no further chunks are added.
- R10: Parameters must be powers of two with `DEV_W` ≤ `MAX_DEV_W` ≤ `BANK_W` ≤ `DATA_BYTES`. This is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_size | input | SZ_W | log2 of the read size in bytes |
| rd_data | output | 8*DATA_BYTES | Registered read data |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
Three instances run on the same stimulus:
- a 4-byte bank of 2-byte devices at full width;
- the same bank with 1-byte devices whose maximum width is 2;
- a legacy instance with device width zero.

Comparing their responses to one address separates full-width normalisation from the extra shift in narrow mode, and both from the old decode. Directed reads cover:
- indices 0 to 3;
- an index whose bit 8 is set and must alias to 0;
- every read size from one byte to two banks;
- a command write in the same cycle as a read.

Seeded random command and read sequences then mix all of these cases.

// File: rtl/flash_id_responder.sv
module flash_id_responder #(
  parameter int BANK_W     = 4,
  parameter int DEV_W      = 2,
  parameter int MAX_DEV_W  = 2,
  parameter int DATA_BYTES = 8,
  parameter int ADDR_W     = 16,
  parameter logic [15:0] MFR_CODE   = 16'h0089,
  parameter logic [15:0] DEV_CODE   = 16'h0018,
  parameter logic [31:0] LEGACY_ID  = 32'h1234_5678,
  parameter logic [7:0]  ARRAY_BYTE = 8'hA5,
  localparam int LGD  = $clog2(DATA_BYTES),
  localparam int SZ_W = (LGD < 2) ? 1 : $clog2(LGD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [SZ_W-1:0]         rd_size,
  output logic [8*DATA_BYTES-1:0] rd_data,
  output logic                    rd_valid
);
  localparam int RW      = 8 * DATA_BYTES;
  localparam int BW      = 8 * BANK_W;
  localparam int NCHUNK  = DATA_BYTES / BANK_W;
  localparam int DW_SAFE = (DEV_W == 0) ? 1 : DEV_W;
  localparam int SHIFT   = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DW_SAFE);
  localparam int LEG_SH  = (BANK_W == 2) ? 1 : (BANK_W == 4) ? 2 : 0;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;

  function automatic bit is_pow2(input int x);
    return (x > 0) && ((x & (x - 1)) == 0);
  endfunction

  initial begin
    assert ((DEV_W == 0) || (is_pow2(DEV_W) && is_pow2(MAX_DEV_W) &&
            DEV_W <= MAX_DEV_W && MAX_DEV_W <= BANK_W))
      else $error("R10: device width parameters are inconsistent");
    assert (is_pow2(BANK_W) && is_pow2(DATA_BYTES) && BANK_W <= DATA_BYTES)
      else $error("R10: bank or data width is not a power of two");
  end

  logic id_mode;

  function automatic logic [BW-1:0] bank_query(input logic [ADDR_W-1:0] off);
    logic [7:0]    idx;
    logic [15:0]   sel;
    logic [BW-1:0] w;
    idx = 8'(off >> SHIFT);
    case (idx)
      8'd0:    sel = MFR_CODE;
      8'd1:    sel = DEV_CODE;
      default: sel = 16'h0000;
    endcase
    for (int b = 0; b < BANK_W; b++)
      w[8*b +: 8] = 8'(sel >> (8 * (b % DW_SAFE)));
    return w;
  endfunction

  function automatic logic [15:0] legacy_query(input logic [ADDR_W-1:0] off);
    logic [7:0] idx;
    idx = off[7:0] >> LEG_SH;
    case (idx)
      8'd0:    return LEGACY_ID[31:16];
      8'd1:    return LEGACY_ID[15:0];
      default: return 16'h0000;
    endcase
  endfunction

  logic [RW-1:0] resp;
  int sz, nbytes;

  always_comb begin
    sz     = (int'(rd_size) > LGD) ? LGD : int'(rd_size);
    nbytes = 1 << sz;
    resp   = '0;
    if (!id_mode) begin
      for (int b = 0; b < DATA_BYTES; b++) resp[8*b +: 8] = ARRAY_BYTE;
    end else if (DEV_W == 0) begin
      resp = RW'(legacy_query(rd_addr));
    end else begin
      for (int c = 0; c < NCHUNK; c++)
        if (c * BANK_W < nbytes)
          resp[c*BW +: BW] = bank_query(rd_addr + ADDR_W'(c * BANK_W));
    end
    for (int b = 0; b < DATA_BYTES; b++)
      if (b >= nbytes) resp[8*b +: 8] = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_mode  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= resp;
      if (wr_en && wr_data == CMD_ID)         id_mode <= 1'b1;
      else if (wr_en && wr_data == CMD_ARRAY) id_mode <= 1'b0;
    end
  end

  assert_enter_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == CMD_ID) |=> id_mode);
  assert_exit_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == CMD_ARRAY) |=> !id_mode);
  assert_other_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != CMD_ID && wr_data != CMD_ARRAY) |=> $stable(id_mode));
  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_valid_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_array_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !id_mode) |=> rd_data[7:0] == ARRAY_BYTE);
endmodule

// File: tb/flash_id_responder_tb.sv
`timescale 1ns/1ps
module flash_id_responder_tb;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0] rd_size = 2'd0;
  logic [63:0] d_full, d_nar, d_leg;
  logic v_full, v_nar, v_leg;
  int checks = 0, errors = 0;
  bit mode = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_id_responder #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(d_full), .rd_valid(v_full));
  flash_id_responder #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2)) u_nar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(d_nar), .rd_valid(v_nar));
  flash_id_responder #(.BANK_W(4), .DEV_W(0), .MAX_DEV_W(2)) u_leg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(d_leg), .rd_valid(v_leg));

  function automatic int lg2(input int x);
    int r = 0;
    while ((1 << r) < x) r++;
    return r;
  endfunction

  function automatic logic [63:0] model(input int dw, input int mw, input bit idm,
                                        input logic [AW-1:0] a, input int size);
    logic [63:0] r = '0;
    int n = 1 << size;
    if (!idm) begin
      for (int b = 0; b < 8; b++) r[8*b +: 8] = 8'hA5;
    end else if (dw == 0) begin
      case (a[7:0] >> 2)
        8'd0: r[15:0] = 16'h1234;
        8'd1: r[15:0] = 16'h5678;
        default: r[15:0] = 16'h0000;
      endcase
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (c * 4 < n) begin
          logic [AW-1:0] o = a + AW'(c * 4);
          logic [7:0] ix = 8'(o >> (2 + lg2(mw) - lg2(dw)));
          logic [15:0] cd = (ix == 8'd0) ? 16'h0089 : (ix == 8'd1) ? 16'h0018 : 16'h0000;
          for (int b = 0; b < 4; b++) r[8*(4*c+b) +: 8] = 8'(cd >> (8 * (b % dw)));
        end
      end
    end
    for (int b = 0; b < 8; b++) if (b >= n) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
    if (c == 8'h90) mode = 1'b1;
    else if (c == 8'hFF) mode = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input int size, input string tf,
                    input string tn, input string tl);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; rd_size = 2'(size);
    @(negedge clk);
    rd_en = 1'b0;
    check({tf, " valid R4"}, 64'(v_full & v_nar & v_leg), 64'd1);
    check(tf, d_full, model(2, 2, mode, a, size));
    check(tn, d_nar, model(1, 2, mode, a, size));
    check(tl, d_leg, model(0, 2, mode, a, size));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid after reset", 64'(v_full | v_nar | v_leg), 64'd0);
    rst_n = 1'b1;
    rd(16'h0000, 3, "R1 R3 array full", "R3 array nar", "R3 array leg");
    @(negedge clk);
    check("R4 valid drops", 64'(v_full), 64'd0);
    cmd(8'h90);
    rd(16'h0000, 3, "R6 R7 idx0/1", "R5 narrow idx0", "R9 legacy idx0");
    check("R7 explicit", d_full, 64'h0018_0018_0089_0089);
    check("R5 narrow explicit", d_nar, 64'h8989_8989_8989_8989);
    rd(16'h0004, 2, "R5 idx1", "R5 narrow shifted", "R9 legacy idx1");
    check("R5 idx1 explicit", d_full, 64'h0000_0000_0018_0018);
    check("R9 legacy explicit", d_leg, 64'h0000_0000_0000_5678);
    rd(16'h0008, 3, "R5 idx2/3 zero", "R5 narrow idx1", "R9 legacy idx2");
    check("R5 zero explicit", d_full, 64'h0);
    rd(16'h0400, 3, "R5 low8 alias", "R5 narrow alias", "R9 legacy alias");
    rd(16'h0000, 0, "R8 one byte", "R8 narrow one byte", "R8 legacy one byte");
    check("R8 explicit", d_full, 64'h89);
    rd(16'h0000, 1, "R8 two bytes", "R8 narrow two", "R8 legacy two");
    cmd(8'h42);
    rd(16'h0000, 2, "R2 other cmd", "R2 other nar", "R2 other leg");
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hFF; rd_en = 1'b1; rd_addr = 16'h0004; rd_size = 2'd2;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R4 same-cycle read uses old mode", d_full, model(2, 2, 1'b1, 16'h0004, 2));
    mode = 1'b0;
    rd(16'h0004, 2, "R2 back to array", "R2 array nar", "R2 array leg");
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 2) begin
        int k = $urandom_range(0, 3);
        cmd(k == 0 ? 8'hFF : k == 3 ? 8'($urandom) : 8'h90);
      end else begin
        logic [AW-1:0] a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 40));
        rd(a, $urandom_range(0, 3), "R5 R6 R7 R8 rand", "R5 R6 narrow rand", "R9 legacy rand");
      end
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule